// File: doc/BRIEF.md
# Bridge Leg Guard-Interval Generator with Current-Polarity Correction

This block sits between a PWM modulator and the gate drivers of a switching output bridge. For every leg it turns one ideal switching command into two gate enables, one for the upper transistor and one for the lower transistor. At every change of the command, the transistor that was conducting is switched off at once. The complementary transistor is switched on only after a guard interval, counted in clock cycles, during which both transistors of the leg are off.

A fixed guard interval distorts the output, because the moment at which the leg voltage really changes depends on which way the load current flows. To correct this, each leg receives a one-bit load-current polarity signal. The block synchronizes it and samples it once per PWM period, on a period-start strobe. It then moves the edge that the current affects by one clock step. The nominal guard length is taken from a configuration input, and that value is also captured only at period starts, so that a period is never switched with a mix of two settings.

A command pulse shorter than the active guard interval never reaches the gates. The transistor that would have turned on stays off, and the leg returns to the side it came from after a fresh guard interval.

Top module: `deadtime_comp`

## Requirements
- R1: The upper and lower enables of one leg are never high in the same cycle. While rst_n is low, all enables are low. After reset, a leg whose command is low turns on its lower enable within 3 cycles.
- R2: When a leg's command goes from 0 to 1 while its lower enable is on, the lower enable drops on the next clock edge. The upper enable rises after exactly Gr cycles in which both enables are low.
- R3: When a leg's command goes from 1 to 0 while its upper enable is on, the upper enable drops on the next clock edge. The lower enable rises after exactly Gf cycles in which both enables are low.
- R4: The nominal guard G equals guard_cfg captured on a clock edge where period_start is 1. A captured value below 2 is raised to 2. Changes of guard_cfg at any other time have no effect.
- R5: cur_out passes through two flip-flops per leg. The synchronized value is captured as the leg's polarity only on an edge where period_start is 1. A value of 1 means current flows out of the leg. A change of cur_out that is driven just before a period_start edge therefore takes effect only at the following period start.
- R6: With polarity 1, Gr = G-1 and Gf = G (the rising edge is advanced by one step). With polarity 0, Gr = G and Gf = G+1 (the falling edge is delayed by one step).
- R7: If the command reverts during a guard interval, the pending enable never turns on. A new guard interval toward the original side starts from the reverting edge. A pulse lasting P cycles with P < Gr thus gives P+Gf cycles with both enables low and no upper pulse.
- R8: Each leg uses its own polarity. A command change on one leg does not alter the enables of another leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one guard step |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_start | input | 1 | One-cycle strobe at each PWM period boundary |
| leg_cmd | input | NUM_LEGS | Ideal leg commands, 1 = upper side |
| cur_out | input | NUM_LEGS | Asynchronous load-current polarity per leg, 1 = out of leg |
| guard_cfg | input | GUARD_W | Nominal guard length in cycles |
| hs_en | output | NUM_LEGS | Upper transistor enables |
| ls_en | output | NUM_LEGS | Lower transistor enables |

## Verification
A wrong counter load or polarity shows at the ports as a guard interval that is one cycle too long or too short. It is visible on the very next command edge, so the bench measures every guard in cycles at the gate enables. A captured guard or polarity that changed off a period start appears as a guard length from the wrong setting on the first transition after that change. A state machine that lets a short pulse through shows as an upper-enable glitch, or as a wrong count of both-off cycles, within one guard interval of the pulse.

// File: rtl/dti_pkg.sv
package dti_pkg;

    // Encoding chosen so that bit 1 is the upper enable and bit 0 the lower enable.
    typedef enum logic [1:0] {
        ST_DEAD = 2'b00,
        ST_LOW  = 2'b01,
        ST_HIGH = 2'b10
    } leg_state_e;

endpackage

// File: rtl/dti_sync.sv
module dti_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
        end
    end

    assign sync_out = stab_q;
endmodule

// File: rtl/dti_leg.sv
module dti_leg
    import dti_pkg::*;
#(
    parameter int GUARD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd,
    input  logic [GUARD_W-1:0] guard,
    input  logic               pol,
    output logic               hs_en,
    output logic               ls_en
);
    typedef struct packed {
        leg_state_e         state;
        logic               dir;
        logic [GUARD_W-1:0] cnt;
    } leg_regs_t;

    leg_regs_t r_q, r_d;
    logic [GUARD_W-1:0] pol_w;
    logic [GUARD_W-1:0] load_rise;
    logic [GUARD_W-1:0] load_fall;

    assign pol_w = {{(GUARD_W-1){1'b0}}, pol};

    always_comb begin
        // Counter holds (guard length - 1); guard >= 2 keeps both loads >= 0.
        load_rise = guard - pol_w - 1'b1;
        load_fall = guard - pol_w;
        r_d = r_q;
        unique case (r_q.state)
            ST_LOW: begin
                if (cmd) begin
                    r_d.state = ST_DEAD;
                    r_d.dir   = 1'b1;
                    r_d.cnt   = load_rise;
                end
            end
            ST_HIGH: begin
                if (!cmd) begin
                    r_d.state = ST_DEAD;
                    r_d.dir   = 1'b0;
                    r_d.cnt   = load_fall;
                end
            end
            default: begin
                if (cmd != r_q.dir) begin
                    r_d.dir = cmd;
                    r_d.cnt = cmd ? load_rise : load_fall;
                end else if (r_q.cnt == '0) begin
                    r_d.state = r_q.dir ? ST_HIGH : ST_LOW;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_DEAD, dir: 1'b0, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign hs_en = r_q.state[1];
    assign ls_en = r_q.state[0];

    always_comb begin
        p_no_overlap_r1: assert (!(hs_en && ls_en))
            else $error("upper and lower enable overlap");
    end

    p_hs_after_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> !$past(ls_en));

    p_ls_after_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> !$past(hs_en));

    p_hs_needs_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> $past(cmd));

    p_ls_needs_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> !$past(cmd));

    p_drop_on_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_en && cmd) |=> !ls_en);
endmodule

// File: rtl/deadtime_comp.sv
module deadtime_comp #(
    parameter int NUM_LEGS  = 2,
    parameter int GUARD_W   = 4,
    parameter int GUARD_RST = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                period_start,
    input  logic [NUM_LEGS-1:0] leg_cmd,
    input  logic [NUM_LEGS-1:0] cur_out,
    input  logic [GUARD_W-1:0]  guard_cfg,
    output logic [NUM_LEGS-1:0] hs_en,
    output logic [NUM_LEGS-1:0] ls_en
);
    localparam logic [GUARD_W-1:0] GUARD_MIN  = GUARD_W'(2);
    localparam logic [GUARD_W-1:0] GUARD_INIT = GUARD_W'(GUARD_RST);

    typedef struct packed {
        logic [GUARD_W-1:0]  guard;
        logic [NUM_LEGS-1:0] pol;
    } cfg_regs_t;

    cfg_regs_t c_q, c_d;
    logic [NUM_LEGS-1:0] sign_s;

    dti_sync #(.WIDTH(NUM_LEGS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cur_out),
        .sync_out (sign_s)
    );

    always_comb begin
        c_d = c_q;
        if (period_start) begin
            c_d.guard = (guard_cfg < GUARD_MIN) ? GUARD_MIN : guard_cfg;
            c_d.pol   = sign_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{guard: (GUARD_INIT < GUARD_MIN) ? GUARD_MIN : GUARD_INIT,
                     pol: '0};
        end else begin
            c_q <= c_d;
        end
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        dti_leg #(.GUARD_W(GUARD_W)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd   (leg_cmd[g]),
            .guard (c_q.guard),
            .pol   (c_q.pol[g]),
            .hs_en (hs_en[g]),
            .ls_en (ls_en[g])
        );
    end

    p_guard_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> $stable(c_q.guard));

    p_guard_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.guard >= GUARD_MIN);

    p_pol_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> $stable(c_q.pol));
endmodule

// File: tb/tb_deadtime_comp.sv
`timescale 1ns/1ps
module tb_deadtime_comp;
    localparam int NL = 2;
    localparam int GW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          period_start = 1'b0;
    logic [NL-1:0] leg_cmd = '0;
    logic [NL-1:0] cur_out = '0;
    logic [GW-1:0] guard_cfg = 4'd4;
    logic [NL-1:0] hs_en, ls_en;

    int checks = 0;
    int errors = 0;
    int overlaps = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    deadtime_comp #(.NUM_LEGS(NL), .GUARD_W(GW), .GUARD_RST(4)) dut (
        .clk(clk), .rst_n(rst_n), .period_start(period_start),
        .leg_cmd(leg_cmd), .cur_out(cur_out), .guard_cfg(guard_cfg),
        .hs_en(hs_en), .ls_en(ls_en)
    );

    always @(negedge clk) begin
        for (int i = 0; i < NL; i++)
            if (hs_en[i] && ls_en[i]) overlaps++;
    end

    // Fields: cfg[10:7], sign[6], dir[5] (1 = rising command), expected gap[4:0]
    localparam int NV = 8;
    localparam logic [10:0] VEC [NV] = '{
        {4'd4,  1'b1, 1'b1, 5'd3},
        {4'd4,  1'b1, 1'b0, 5'd4},
        {4'd4,  1'b0, 1'b1, 5'd4},
        {4'd4,  1'b0, 1'b0, 5'd5},
        {4'd1,  1'b1, 1'b1, 5'd1},
        {4'd0,  1'b0, 1'b0, 5'd3},
        {4'd15, 1'b0, 1'b0, 5'd16},
        {4'd15, 1'b1, 1'b1, 5'd14}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_params(input logic [GW-1:0] cfg, input logic s0, input logic s1);
        @(negedge clk);
        guard_cfg = cfg;
        cur_out = {s1, s0};
        repeat (3) @(negedge clk);
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
    endtask

    task automatic settle(input int leg, input logic lvl);
        @(negedge clk);
        leg_cmd[leg] = lvl;
        repeat (40) @(negedge clk);
    endtask

    // Drive a command edge and count samples with both enables low.
    task automatic measure(input int leg, input logic lvl, output int gap, output bit side_ok);
        gap = 0;
        @(negedge clk);
        leg_cmd[leg] = lvl;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (!hs_en[leg] && !ls_en[leg]) gap++;
            else break;
        end
        side_ok = (hs_en[leg] == lvl) && (ls_en[leg] == !lvl);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int gap;
        bit ok;
        bit hs_seen;
        logic [10:0] v;
        logic hold_hs;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(hs_en == '0 && ls_en == '0, "R1 enables low in reset", {hs_en, ls_en}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(ls_en == '1 && hs_en == '0, "R1 lower side on after reset", {hs_en, ls_en}, 3);

        // R2/R3/R6: table of guard settings, polarities and edge directions
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            set_params(v[10:7], v[6], 1'b0);
            settle(0, !v[5]);
            measure(0, v[5], gap, ok);
            check(gap == int'(v[4:0]), v[5] ? "R2 R6 rising guard" : "R3 R6 falling guard",
                  gap, int'(v[4:0]));
            check(ok, v[5] ? "R2 upper side on" : "R3 lower side on", int'(ok), 1);
        end

        // R4: guard_cfg ignored until a period start
        set_params(4'd4, 1'b0, 1'b0);
        settle(0, 1'b0);
        @(negedge clk);
        guard_cfg = 4'd9;
        repeat (3) @(negedge clk);
        measure(0, 1'b1, gap, ok);
        check(gap == 4, "R4 guard held without period start", gap, 4);
        set_params(4'd9, 1'b0, 1'b0);
        settle(0, 1'b0);
        measure(0, 1'b1, gap, ok);
        check(gap == 9, "R4 guard taken at period start", gap, 9);

        // R5: polarity needs two synchronizer stages before capture
        set_params(4'd4, 1'b0, 1'b0);
        settle(0, 1'b0);
        @(negedge clk);
        cur_out[0] = 1'b1;
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
        measure(0, 1'b1, gap, ok);
        check(gap == 4, "R5 late polarity not yet captured", gap, 4);
        settle(0, 1'b0);
        @(negedge clk);
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
        measure(0, 1'b1, gap, ok);
        check(gap == 3, "R5 polarity captured next period", gap, 3);

        // R7: short pulses are swallowed (G=4, pol 0: Gr=4, Gf=5)
        for (int p = 1; p <= 3; p++) begin
            set_params(4'd4, 1'b0, 1'b0);
            settle(0, 1'b0);
            hs_seen = 1'b0;
            gap = 0;
            @(negedge clk);
            leg_cmd[0] = 1'b1;
            for (int k = 0; k < p; k++) begin
                @(negedge clk);
                if (hs_en[0]) hs_seen = 1'b1;
                if (!hs_en[0] && !ls_en[0]) gap++;
            end
            leg_cmd[0] = 1'b0;
            for (int k = 0; k < 64; k++) begin
                @(negedge clk);
                if (hs_en[0]) hs_seen = 1'b1;
                if (!hs_en[0] && !ls_en[0]) gap++;
                else break;
            end
            check(!hs_seen, "R7 no upper glitch", int'(hs_seen), 0);
            check(gap == p + 5 && ls_en[0], "R7 gap after short pulse", gap, p + 5);
        end

        // R8: per-leg polarity and independence
        set_params(4'd5, 1'b1, 1'b0);
        settle(0, 1'b0);
        settle(1, 1'b0);
        measure(1, 1'b1, gap, ok);
        check(gap == 5 && ok, "R8 leg1 uses its own polarity", gap, 5);
        hold_hs = hs_en[1];
        measure(0, 1'b1, gap, ok);
        check(gap == 4 && ok, "R8 leg0 uses its own polarity", gap, 4);
        check(hs_en[1] == hold_hs && !ls_en[1], "R8 leg1 undisturbed", int'(hs_en[1]), 1);

        check(overlaps == 0, "R1 no overlap seen", overlaps, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule